// File: doc/BRIEF.md
# Channel-Status, User and Validity Side-Bit Output Unit

This unit sits behind a biphase decoder. For every decoded subframe it receives the channel-status (C), user (U) and validity (V) bits, together with a one-cycle strobe, a flag that says whether the subframe is left or right, and a marker that flags the first frame of a 192-frame block. It stores these bits for each channel. It then drives them out as three serial lines that step once per half-period of the recovered word clock. Each bit appears when the word clock enters the half that belongs to its channel.

A block-start flag output goes high when the marked left subframe is presented and stays high for eight word-clock periods. In parallel, the unit collects the C bits of the left subframes of frames 0 to 47 of each block into a 48-bit word. It publishes that word in a single step, with a one-cycle update pulse, once bit 47 has arrived. A select input decides whether V is presented with its sample or passed straight through when it is decoded. A format input decides which word-clock level means left.

Top module: `csuv_out_unit`

## Requirements
- R1: While rstN is low and right after its release, cOut, uOut, vOut, bframe and csUpdate are 0 and csReg is all zeros.
- R2: When lrck changes level, at the next clock edge cOut and uOut show the C and U bits of the most recently strobed subframe of the channel that lrck now selects.
- R3: Between lrck level changes, cOut and uOut hold their value, whatever strobes arrive.
- R4: If a subframe strobe arrives in the same cycle as an lrck change into that subframe's channel, the outputs show the previously stored bits of that channel. The new bits are kept and shown at the following entry into that channel.
- R5: With vAlign = 1, vOut follows the same timing as cOut (R2, R3). With vAlign = 0, vOut takes the strobed V bit at the clock edge that registers the strobe, with no regard to lrck.
- R6: With fmtI2s = 1, lrck low selects the left channel. With fmtI2s = 0, lrck high selects the left channel.
- R7: bframe rises at the left-channel entry that presents the subframe carrying blkStart. It stays high through the next 7 left-channel entries and falls at the 8th, so it is high for 8 lrck periods.
- R8: csReg bit i (i = 0..47) holds the C bit of the left subframe of frame i, where frame 0 is the left subframe strobed with blkStart = 1. The whole word changes in a single cycle.
- R9: csUpdate is high for exactly one cycle, in the same cycle that csReg takes a new value. csReg changes in no other cycle.
- R10: A blkStart on a left subframe restarts the frame count at 0 even inside a block. C bits collected before it are never published, and the next update holds only bits gathered after the restart.
- R11: If the left subframe that follows frame 191 carries no blkStart, frame counting and collection stop, and no update occurs until the next blkStart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| subStb | input | 1 | One-cycle strobe: a decoded subframe is available |
| subIsLeft | input | 1 | 1 = the strobed subframe is a left subframe |
| blkStart | input | 1 | The strobed subframe is frame 0 of a block |
| cBit | input | 1 | Decoded channel-status bit |
| uBit | input | 1 | Decoded user bit |
| vBit | input | 1 | Decoded validity bit |
| lrck | input | 1 | Recovered word clock, synchronous to clk |
| vAlign | input | 1 | 1 = V aligned to its sample, 0 = V passed through when decoded |
| fmtI2s | input | 1 | 1 = lrck low is left, 0 = lrck high is left |
| cOut | output | 1 | Serial channel-status output |
| uOut | output | 1 | Serial user output |
| vOut | output | 1 | Serial validity output |
| bframe | output | 1 | Block-start flag, 8 lrck periods long |
| csReg | output | 48 | Captured channel-status bits 0..47 of the last complete block |
| csUpdate | output | 1 | One-cycle pulse when csReg is refreshed |

## Verification
Two events can fall in the same cycle: a subframe strobe writing a channel's stored bits, and an lrck level change presenting that same channel's stored bits. The bench provokes this by driving the left-subframe strobe and the lrck move into the left level on one clock. It passes only if the outputs first show the previously stored left bits and show the newly strobed bits at the next left entry. A second collision, a block-start marker landing while a capture is half done, is provoked by a restart after 20 frames. It is judged by the count of update pulses and by the published word, which must hold only bits collected after the restart.

// File: rtl/csuv_pkg.sv
package csuv_pkg;
  // number of channel-status bits collected per block
  localparam int CS_BITS = 48;
  localparam int CS_IDX_W = $clog2(CS_BITS);

  // strobes from control to datapath
  typedef struct packed {
    logic                showLeft;    // lrck entered the left half
    logic                showRight;   // lrck entered the right half
    logic                captWrite;   // store cBit into the capture shadow
    logic                captCommit;  // last capture bit: publish word
    logic [CS_IDX_W-1:0] captIdx;     // shadow bit position for captWrite
  } ctrl_strobe_t;
endpackage

// File: rtl/csuv_ctrl.sv
module csuv_ctrl
  import csuv_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  parameter int BF_PERIODS   = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         subStb,
  input  logic         subIsLeft,
  input  logic         blkStart,
  input  logic         lrck,
  input  logic         fmtI2s,
  output ctrl_strobe_t stb,
  output logic         bframe
);
  localparam int FRAME_W = $clog2(BLOCK_FRAMES);
  localparam int BF_W    = $clog2(BF_PERIODS + 1);
  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(BLOCK_FRAMES - 1);
  localparam logic [FRAME_W-1:0] LAST_CAPT  = FRAME_W'(CS_BITS - 1);

  logic               lrckQ;
  logic               lrckEdge;
  logic               leftLevel;
  logic               enterLeft;
  logic               enterRight;
  logic               leftStb;
  logic               inBlock;
  logic [FRAME_W-1:0] frameIdx;
  logic               blkPend;
  logic [BF_W-1:0]    bfRemain;

  // word clock edge detection and channel decision
  always_ff @(posedge clk) begin
    if (!rstN) lrckQ <= 1'b0;
    else       lrckQ <= lrck;
  end

  assign leftLevel  = ~fmtI2s;
  assign lrckEdge   = lrck ^ lrckQ;
  assign enterLeft  = lrckEdge && (lrck == leftLevel);
  assign enterRight = lrckEdge && (lrck != leftLevel);
  assign leftStb    = subStb && subIsLeft;

  // frame counting within a block
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBlock  <= 1'b0;
      frameIdx <= '0;
    end else if (leftStb) begin
      if (blkStart) begin
        inBlock  <= 1'b1;
        frameIdx <= '0;
      end else if (inBlock && frameIdx < LAST_FRAME) begin
        frameIdx <= frameIdx + 1'b1;
      end else begin
        inBlock  <= 1'b0;
      end
    end
  end

  // capture strobes
  always_comb begin
    stb.showLeft   = enterLeft;
    stb.showRight  = enterRight;
    stb.captWrite  = 1'b0;
    stb.captIdx    = '0;
    if (leftStb) begin
      if (blkStart) begin
        stb.captWrite = 1'b1;
      end else if (inBlock && frameIdx < LAST_CAPT) begin
        stb.captWrite = 1'b1;
        stb.captIdx   = CS_IDX_W'(frameIdx + 1'b1);
      end
    end
    stb.captCommit = stb.captWrite && (stb.captIdx == CS_IDX_W'(CS_BITS - 1));
  end

  // block-start flag, counted in left-channel entries
  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkPend  <= 1'b0;
      bframe   <= 1'b0;
      bfRemain <= '0;
    end else if (enterLeft) begin
      blkPend <= leftStb && blkStart;
      if (blkPend) begin
        bframe   <= 1'b1;
        bfRemain <= BF_W'(BF_PERIODS);
      end else if (bframe) begin
        if (bfRemain == BF_W'(1)) bframe <= 1'b0;
        bfRemain <= bfRemain - 1'b1;
      end
    end else if (leftStb && blkStart) begin
      blkPend <= 1'b1;
    end
  end
endmodule

// File: rtl/csuv_dpath.sv
module csuv_dpath
  import csuv_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       stb,
  input  logic               subStb,
  input  logic               subIsLeft,
  input  logic               cBit,
  input  logic               uBit,
  input  logic               vBit,
  input  logic               vAlign,
  output logic               cOut,
  output logic               uOut,
  output logic               vOut,
  output logic [CS_BITS-1:0] csReg,
  output logic               csUpdate
);
  localparam int NCH = 2;   // index 0 left, 1 right

  logic [2:0]         pend [NCH];
  logic [2:0]         shown;
  logic [CS_BITS-1:0] shadow;
  logic [CS_BITS-1:0] wrHit;
  logic [CS_BITS-1:0] shadowNext;

  // per-channel side-bit holding registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int ch = 0; ch < NCH; ch++) pend[ch] <= '0;
    end else if (subStb) begin
      pend[subIsLeft ? 0 : 1] <= {cBit, uBit, vBit};
    end
  end

  assign shown = stb.showLeft ? pend[0] : pend[1];

  // serial outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cOut <= 1'b0;
      uOut <= 1'b0;
      vOut <= 1'b0;
    end else begin
      if (stb.showLeft || stb.showRight) begin
        cOut <= shown[2];
        uOut <= shown[1];
        if (vAlign) vOut <= shown[0];
      end
      if (!vAlign && subStb) vOut <= vBit;
    end
  end

  // one-hot write decode of the capture shadow
  for (genvar b = 0; b < CS_BITS; b++) begin : g_hit
    assign wrHit[b] = stb.captWrite && (stb.captIdx == CS_IDX_W'(b));
  end

  assign shadowNext = (shadow & ~wrHit) | ({CS_BITS{cBit}} & wrHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow   <= '0;
      csReg    <= '0;
      csUpdate <= 1'b0;
    end else begin
      shadow   <= shadowNext;
      csUpdate <= stb.captCommit;
      if (stb.captCommit) csReg <= shadowNext;
    end
  end
endmodule

// File: rtl/csuv_out_unit.sv
module csuv_out_unit
  import csuv_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  parameter int BF_PERIODS   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               subStb,
  input  logic               subIsLeft,
  input  logic               blkStart,
  input  logic               cBit,
  input  logic               uBit,
  input  logic               vBit,
  input  logic               lrck,
  input  logic               vAlign,
  input  logic               fmtI2s,
  output logic               cOut,
  output logic               uOut,
  output logic               vOut,
  output logic               bframe,
  output logic [CS_BITS-1:0] csReg,
  output logic               csUpdate
);
  ctrl_strobe_t stb;

  csuv_ctrl #(
    .BLOCK_FRAMES(BLOCK_FRAMES),
    .BF_PERIODS  (BF_PERIODS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .subStb   (subStb),
    .subIsLeft(subIsLeft),
    .blkStart (blkStart),
    .lrck     (lrck),
    .fmtI2s   (fmtI2s),
    .stb      (stb),
    .bframe   (bframe)
  );

  csuv_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .subStb   (subStb),
    .subIsLeft(subIsLeft),
    .cBit     (cBit),
    .uBit     (uBit),
    .vBit     (vBit),
    .vAlign   (vAlign),
    .cOut     (cOut),
    .uOut     (uOut),
    .vOut     (vOut),
    .csReg    (csReg),
    .csUpdate (csUpdate)
  );
endmodule

// File: rtl/csuv_out_unit_chk.sv
module csuv_out_unit_chk
  import csuv_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               lrck,
  input logic               fmtI2s,
  input logic               vAlign,
  input logic               cOut,
  input logic               uOut,
  input logic               vOut,
  input logic               bframe,
  input logic [CS_BITS-1:0] csReg,
  input logic               csUpdate
);
  // R9
  cs_update_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    csUpdate |=> !csUpdate);

  // R9
  cs_reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csUpdate |-> $stable(csReg));

  // R3
  cu_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lrck == $past(lrck)) |=> ($stable(cOut) && $stable(uOut)));

  // R5
  v_aligned_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vAlign && (lrck == $past(lrck))) |=> $stable(vOut));

  // R7
  bframe_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bframe) |-> (($past(lrck) != $past(lrck, 2)) && ($past(lrck) == !$past(fmtI2s))));
endmodule

bind csuv_out_unit csuv_out_unit_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .lrck    (lrck),
  .fmtI2s  (fmtI2s),
  .vAlign  (vAlign),
  .cOut    (cOut),
  .uOut    (uOut),
  .vOut    (vOut),
  .bframe  (bframe),
  .csReg   (csReg),
  .csUpdate(csUpdate)
);

// File: tb/csuv_out_unit_tb.sv
module csuv_out_unit_tb;
  localparam int CSB = 48;
  // walk table: [3] left subframe, [2] C, [1] U, [0] V; expected outputs equal the strobed bits
  localparam logic [3:0] VEC [8] = '{4'b1101, 4'b0011, 4'b1110, 4'b0000,
                                     4'b1111, 4'b0100, 4'b1001, 4'b0010};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic subStb = 1'b0, subIsLeft = 1'b0, blkStart = 1'b0;
  logic cBit = 1'b0, uBit = 1'b0, vBit = 1'b0;
  logic lrck = 1'b0, vAlign = 1'b1, fmtI2s = 1'b1;
  logic cOut, uOut, vOut, bframe, csUpdate;
  logic [CSB-1:0] csReg;

  int checks = 0;
  int failures = 0;
  int updCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  csuv_out_unit u_dut (
    .clk(clk), .rstN(rstN), .subStb(subStb), .subIsLeft(subIsLeft),
    .blkStart(blkStart), .cBit(cBit), .uBit(uBit), .vBit(vBit),
    .lrck(lrck), .vAlign(vAlign), .fmtI2s(fmtI2s),
    .cOut(cOut), .uOut(uOut), .vOut(vOut), .bframe(bframe),
    .csReg(csReg), .csUpdate(csUpdate)
  );

  always @(posedge clk) if (rstN && csUpdate) updCnt++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic lvlLeft();
    return ~fmtI2s;
  endfunction

  function automatic logic pat(input int i, input int s);
    return (((i * s) + (i >> 2)) % 3) == 1;
  endfunction

  function automatic logic [CSB-1:0] expCs(input int s);
    logic [CSB-1:0] w;
    for (int i = 0; i < CSB; i++) w[i] = pat(i, s);
    return w;
  endfunction

  task automatic sendSub(input logic l, input logic b, input logic c, input logic u, input logic v);
    @(negedge clk);
    subStb = 1'b1; subIsLeft = l; blkStart = b; cBit = c; uBit = u; vBit = v;
    @(negedge clk);
    subStb = 1'b0; blkStart = 1'b0;
  endtask

  task automatic setLrck(input logic lv);
    @(negedge clk);
    lrck = lv;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doFrame(input logic b, input logic c, output logic bfAtLeft);
    sendSub(1'b1, b, c, 1'b0, 1'b0);
    setLrck(lvlLeft());
    bfAtLeft = bframe;
    sendSub(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    setLrck(~lvlLeft());
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin : main
    logic bf;
    int base;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 cOut", cOut, 0);
    check("R1 uOut", uOut, 0);
    check("R1 vOut", vOut, 0);
    check("R1 bframe", bframe, 0);
    check("R1 csUpdate", csUpdate, 0);
    check("R1 csReg", csReg, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 csReg after release", csReg, 0);

    // table walk, I2S polarity, V aligned
    setLrck(1'b1);
    for (int k = 0; k < 8; k++) begin
      logic [3:0] e;
      logic pc, pu;
      e = VEC[k];
      pc = cOut; pu = uOut;
      sendSub(e[3], 1'b0, e[2], e[1], e[0]);
      @(negedge clk);
      check("R3 cOut hold", cOut, pc);
      check("R3 uOut hold", uOut, pu);
      setLrck(e[3] ? lvlLeft() : ~lvlLeft());
      check("R2 cOut", cOut, e[2]);
      check("R2 uOut", uOut, e[1]);
      check("R5 vOut aligned", vOut, e[0]);
    end

    // R5 immediate validity
    vAlign = 1'b0;
    sendSub(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R5 vOut immediate set", vOut, 1);
    sendSub(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 vOut immediate clear", vOut, 0);
    vAlign = 1'b1;

    // R4 strobe and lrck edge into same channel in one cycle
    sendSub(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    setLrck(lvlLeft());
    check("R4 setup cOut", cOut, 1);
    sendSub(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    setLrck(~lvlLeft());
    @(negedge clk);
    subStb = 1'b1; subIsLeft = 1'b1; cBit = 1'b0; uBit = 1'b0; vBit = 1'b0;
    lrck = lvlLeft();
    @(negedge clk);
    subStb = 1'b0;
    @(negedge clk);
    check("R4 old cOut shown", cOut, 1);
    check("R4 old uOut shown", uOut, 1);
    setLrck(~lvlLeft());
    setLrck(lvlLeft());
    check("R4 new cOut shown", cOut, 0);

    // R6 non-I2S polarity: lrck high is left
    fmtI2s = 1'b0;
    sendSub(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    sendSub(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    setLrck(1'b1);
    check("R6 left at high cOut", cOut, 1);
    check("R6 left at high uOut", uOut, 0);
    setLrck(1'b0);
    check("R6 right at low cOut", cOut, 0);
    check("R6 right at low uOut", uOut, 1);
    fmtI2s = 1'b1;
    setLrck(1'b1);

    // R7, R8, R9: a full block
    base = updCnt;
    for (int f = 0; f < 192; f++) begin
      doFrame(f == 0, pat(f, 5), bf);
      if (f <= 7) check("R7 bframe high", bf, 1);
      if (f == 8) check("R7 bframe low after 8", bf, 0);
      if (f == 46) check("R9 no update before bit 47", updCnt - base, 0);
    end
    check("R9 one update per block", updCnt - base, 1);
    check("R8 csReg content", csReg, expCs(5));

    // R11 missing marker after frame 191
    base = updCnt;
    for (int f = 0; f < 60; f++) doFrame(1'b0, pat(f, 7), bf);
    check("R11 no update without marker", updCnt - base, 0);
    check("R11 csReg kept", csReg, expCs(5));

    // R10 early marker restart
    base = updCnt;
    for (int f = 0; f < 20; f++) doFrame(f == 0, pat(f, 3), bf);
    check("R10 no update from partial", updCnt - base, 0);
    for (int f = 0; f < 48; f++) doFrame(f == 0, pat(f, 7), bf);
    check("R10 one update after restart", updCnt - base, 1);
    check("R10 csReg from restart", csReg, expCs(7));

    done = 1'b1;
    report();
  end
endmodule